// File: doc/BRIEF.md
# EDID Serial-EEPROM Load/Store Engine

This block moves EDID bytes between a small external serial EEPROM, reached over a four-wire SPI link, and the on-chip EDID RAM. A load reads the EEPROM from address zero upward and writes every byte into the RAM in order. A store does the opposite: it copies the RAM into the EEPROM page by page so the EDID can be programmed in system. The EEPROM can be 256 bytes or 512 bytes deep, chosen by a strap input.

A load starts without any command when the block leaves reset while the power-down input is low. Outside of that, the host starts work through two self-clearing command bits, one for load and one for store. The engine answers each set bit with a one-cycle clear pulse. The bit only takes effect when the engine is idle. The SPI clock is the free-running oscillator clock divided down, with each SCK phase lasting `DIV_HALF` oscillator cycles. The EDID RAM port has a one-cycle registered read.

Top module: `edidXferEngine`

## Requirements
- R1: After a reset with `pwrDnN` high, the engine stays idle: `busy` is low, `csN` is high, `sck` is low and `ramWe` is never asserted.
- R2: After a reset with `pwrDnN` low, a load starts without a command. It sends read opcode 0x03 and address byte 0x00, then writes the streamed bytes into RAM addresses 0, 1, 2 and so on, 512 bytes in all when `bigPart` is 1.
- R3: With `bigPart` at 0, a load writes exactly 256 RAM bytes and leaves addresses 256 to 511 untouched. A store programs 16 pages, and every write opcode is 0x02.
- R4: A load bit seen while idle gives a one-cycle `loadClr` pulse, and `busy` is high in the next cycle.
- R5: A command bit seen while busy receives its clear pulse but is dropped. It starts no operation, either during the current one or after it.
- R6: A store handles the memory in pages of 2^PAGE_LOG bytes (16 by default). Each page uses three transaction types, each framed by its own chip-select low period:
  - a write-enable transaction with opcode 0x06;
  - a page-write transaction with opcode 0x02, where bit 3 of the opcode carries address bit 8 (so 0x0A is used for the upper half), followed by the low address byte and the page data;
  - status reads with opcode 0x05, repeated while status bit 0 is 1.
- R7: When a store completes, the EEPROM holds a byte-for-byte copy of the RAM over the selected depth.
- R8: With no EEPROM fitted, `miso` reads as 0 and a load fills the RAM with zeros.
- R9: Each SCK high phase lasts `DIV_HALF` clocks. SCK is low whenever `csN` is high.
- R10: The SPI link uses mode 0. MOSI only changes while SCK is low, and MISO is captured on the rising SCK edge.
- R11: If both command bits are seen in the same idle cycle, the load runs, both bits are cleared, and the store is dropped.
- R12: `busy` stays high for the whole operation. `done` is a one-cycle pulse in the first cycle in which `busy` is low again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwrDnN | input | 1 | Low selects EDID power-down mode; sampled on leaving reset |
| bigPart | input | 1 | 1: 512-byte EEPROM, 0: 256-byte EEPROM |
| loadBit | input | 1 | Load command bit (self-clearing) |
| storeBit | input | 1 | Store command bit (self-clearing) |
| loadClr | output | 1 | One-cycle pulse that clears the load bit |
| storeClr | output | 1 | One-cycle pulse that clears the store bit |
| busy | output | 1 | High while an operation runs |
| done | output | 1 | One-cycle completion pulse |
| ramAddr | output | 9 | EDID RAM byte address |
| ramWe | output | 1 | EDID RAM write strobe |
| ramWdata | output | 8 | EDID RAM write data |
| ramRdata | input | 8 | EDID RAM read data, one cycle after the address |
| sck | output | 1 | SPI serial clock |
| csN | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the EEPROM |
| miso | input | 1 | SPI data from the EEPROM (pulled down) |

## Verification
The assertions assume that the EEPROM answers in mode 0. They also assume that the host holds a command bit until it sees the matching clear pulse, and that reset is the only thing that restarts the boot check. The bench's EEPROM model changes MISO only on falling SCK edges. It keeps write-in-progress set for three status reads after every page commit. The bench raises and drops command bits only on falling clock edges, and it clears each bit in the cycle its clear pulse appears.

// File: rtl/edidXferPkg.sv
package edidXferPkg;
  localparam int EE_ADDR_W = 9;

  typedef struct packed {
    logic       go;      // start one byte slot
    logic       quiet;   // slot with chip select high and no clock
    logic       useRam;  // transmit the RAM read data
    logic [7:0] txByte;  // otherwise transmit this byte
  } spiCmd_t;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LD_OP, ST_LD_ADR, ST_LD_DAT,
    ST_WE_OP, ST_WE_GAP, ST_WR_OP, ST_WR_ADR, ST_WR_DAT, ST_WR_GAP,
    ST_RS_OP, ST_RS_DAT, ST_RS_GAP, ST_FIN
  } xferState_e;
endpackage

// File: rtl/edidXferPath.sv
module edidXferPath
  import edidXferPkg::*;
#(
  parameter int DIV_HALF = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  spiCmd_t    cmd,
  input  logic [7:0] ramRdata,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byteDone,
  output logic [7:0] rxByte
);
  localparam int DW = $clog2(DIV_HALF + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [DW-1:0] divCnt;
  logic          active, quietR, sckR;
  logic [7:0]    txSh, rxSh;
  logic [2:0]    bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt   <= '0;
      active   <= 1'b0;
      quietR   <= 1'b0;
      sckR     <= 1'b0;
      txSh     <= '0;
      rxSh     <= '0;
      bitCnt   <= '0;
      byteDone <= 1'b0;
    end else begin
      byteDone <= 1'b0;
      if (cmd.go) begin
        active <= 1'b1;
        quietR <= cmd.quiet;
        txSh   <= cmd.useRam ? ramRdata : cmd.txByte;
        bitCnt <= '0;
        divCnt <= '0;
        sckR   <= 1'b0;
      end else if (active) begin
        if (divCnt == DIV_LAST) begin
          divCnt <= '0;
          if (!sckR) begin
            sckR <= 1'b1;
            rxSh <= {rxSh[6:0], miso};
          end else begin
            sckR <= 1'b0;
            if (bitCnt == 3'd7) begin
              active   <= 1'b0;
              byteDone <= 1'b1;
            end else begin
              bitCnt <= bitCnt + 3'd1;
              txSh   <= {txSh[6:0], 1'b0};
            end
          end
        end else begin
          divCnt <= divCnt + DW'(1);
        end
      end
    end
  end

  assign sck    = sckR & ~quietR;
  assign mosi   = txSh[7];
  assign rxByte = rxSh;
endmodule

// File: rtl/edidXferCtrl.sv
module edidXferCtrl
  import edidXferPkg::*;
#(
  parameter int PAGE_LOG = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 pwrDnN,
  input  logic                 bigPart,
  input  logic                 loadBit,
  input  logic                 storeBit,
  input  logic                 byteDone,
  input  logic                 statusWip,
  output spiCmd_t              cmd,
  output logic                 csN,
  output logic                 ramWe,
  output logic [EE_ADDR_W-1:0] ramAddr,
  output logic                 busy,
  output logic                 done,
  output logic                 loadClr,
  output logic                 storeClr
);
  localparam logic [PAGE_LOG-1:0] PAGE_END = '1;

  xferState_e           state;
  logic [EE_ADDR_W-1:0] addr, lastAddr;
  logic                 bootPend, kick, kickD, wip, endHit, a8;

  assign lastAddr = bigPart ? {EE_ADDR_W{1'b1}} : EE_ADDR_W'(8'hFF);
  assign a8       = bigPart & addr[8];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      addr     <= '0;
      bootPend <= 1'b1;
      kick     <= 1'b0;
      kickD    <= 1'b0;
      wip      <= 1'b0;
      endHit   <= 1'b0;
      done     <= 1'b0;
      loadClr  <= 1'b0;
      storeClr <= 1'b0;
    end else begin
      kick     <= 1'b0;
      kickD    <= kick;
      done     <= 1'b0;
      loadClr  <= 1'b0;
      storeClr <= 1'b0;
      bootPend <= 1'b0;
      if (state == ST_IDLE) begin
        addr   <= '0;
        endHit <= 1'b0;
        if (bootPend && !pwrDnN) begin
          state <= ST_LD_OP;
          kick  <= 1'b1;
        end else if (loadBit) begin
          state    <= ST_LD_OP;
          kick     <= 1'b1;
          loadClr  <= 1'b1;
          storeClr <= storeBit;
        end else if (storeBit) begin
          state    <= ST_WE_OP;
          kick     <= 1'b1;
          storeClr <= 1'b1;
        end
      end else if (state == ST_FIN) begin
        loadClr  <= loadBit;
        storeClr <= storeBit;
        state    <= ST_IDLE;
        done     <= 1'b1;
      end else begin
        loadClr  <= loadBit;
        storeClr <= storeBit;
        if (byteDone) begin
          kick <= 1'b1;
          unique case (state)
            ST_LD_OP:  state <= ST_LD_ADR;
            ST_LD_ADR: state <= ST_LD_DAT;
            ST_LD_DAT: begin
              addr <= addr + 1'b1;
              if (addr == lastAddr) begin
                state <= ST_FIN;
                kick  <= 1'b0;
              end
            end
            ST_WE_OP:  state <= ST_WE_GAP;
            ST_WE_GAP: state <= ST_WR_OP;
            ST_WR_OP:  state <= ST_WR_ADR;
            ST_WR_ADR: state <= ST_WR_DAT;
            ST_WR_DAT: begin
              addr <= addr + 1'b1;
              if (addr == lastAddr) endHit <= 1'b1;
              if (addr[PAGE_LOG-1:0] == PAGE_END) state <= ST_WR_GAP;
            end
            ST_WR_GAP: state <= ST_RS_OP;
            ST_RS_OP:  state <= ST_RS_DAT;
            ST_RS_DAT: begin
              wip   <= statusWip;
              state <= ST_RS_GAP;
            end
            ST_RS_GAP: begin
              if (wip) state <= ST_RS_OP;
              else if (endHit) begin
                state <= ST_FIN;
                kick  <= 1'b0;
              end else state <= ST_WE_OP;
            end
            default: state <= ST_IDLE;
          endcase
        end
      end
    end
  end

  always_comb begin
    cmd        = '0;
    cmd.go     = kickD;
    cmd.useRam = (state == ST_WR_DAT);
    cmd.quiet  = (state == ST_WE_GAP) || (state == ST_WR_GAP) || (state == ST_RS_GAP);
    unique case (state)
      ST_LD_OP:  cmd.txByte = {4'b0000, a8, 3'b011};
      ST_WR_OP:  cmd.txByte = {4'b0000, a8, 3'b010};
      ST_LD_ADR, ST_WR_ADR: cmd.txByte = addr[7:0];
      ST_WE_OP:  cmd.txByte = 8'h06;
      ST_RS_OP:  cmd.txByte = 8'h05;
      default:   cmd.txByte = 8'h00;
    endcase
  end

  assign csN     = (state == ST_IDLE) || (state == ST_FIN) || cmd.quiet;
  assign busy    = (state != ST_IDLE);
  assign ramWe   = (state == ST_LD_DAT) && byteDone;
  assign ramAddr = addr;
endmodule

// File: rtl/edidXferEngine.sv
module edidXferEngine
  import edidXferPkg::*;
#(
  parameter int DIV_HALF = 8,
  parameter int PAGE_LOG = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pwrDnN,
  input  logic       bigPart,
  input  logic       loadBit,
  input  logic       storeBit,
  output logic       loadClr,
  output logic       storeClr,
  output logic       busy,
  output logic       done,
  output logic [8:0] ramAddr,
  output logic       ramWe,
  output logic [7:0] ramWdata,
  input  logic [7:0] ramRdata,
  output logic       sck,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);
  spiCmd_t    spiCmd;
  logic       byteDone;
  logic [7:0] rxByte;

  edidXferCtrl #(.PAGE_LOG(PAGE_LOG)) u_ctrl (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .bigPart(bigPart),
    .loadBit(loadBit), .storeBit(storeBit), .byteDone(byteDone),
    .statusWip(rxByte[0]), .cmd(spiCmd), .csN(csN), .ramWe(ramWe),
    .ramAddr(ramAddr), .busy(busy), .done(done),
    .loadClr(loadClr), .storeClr(storeClr)
  );

  edidXferPath #(.DIV_HALF(DIV_HALF)) u_path (
    .clk(clk), .rstN(rstN), .cmd(spiCmd), .ramRdata(ramRdata),
    .miso(miso), .sck(sck), .mosi(mosi), .byteDone(byteDone),
    .rxByte(rxByte)
  );

  assign ramWdata = rxByte;
endmodule

// File: rtl/edidXferChk.sv
module edidXferChk (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sck,
  input logic mosi,
  input logic busy,
  input logic done,
  input logic ramWe
);
  // R9
  sck_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  // R1
  cs_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> csN);

  // R12
  done_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  // R2
  ramwe_chk: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> (busy && !csN));

  // R10
  mosi_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sck && $past(sck)) |-> $stable(mosi));
endmodule

bind edidXferEngine edidXferChk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .mosi(mosi),
  .busy(busy), .done(done), .ramWe(ramWe)
);

// File: tb/edidXferEngine_tb.sv
module edidXferEngine_tb;
  localparam int DIVH = 1;
  localparam int PLOG = 4;

  logic clk = 1'b0, rstN = 1'b0, pwrDnN = 1'b1, bigPart = 1'b1;
  logic loadBit = 1'b0, storeBit = 1'b0;
  logic loadClr, storeClr, busy, done, ramWe, sck, csN, mosi, miso;
  logic [8:0] ramAddr;
  logic [7:0] ramWdata, ramRdata;

  int vectors = 0, errors = 0, cycles = 0;
  int weCnt = 0, doneCnt = 0, hiCnt = 0;
  logic prevSck = 1'b0, prevMosi = 1'b0;

  logic [7:0] ram [512];
  logic [7:0] eeMem [512];
  logic eePresent = 1'b1;

  // EEPROM model state
  int bitN = 0, byteN = 0, eAddr = 0, wipLeft = 0;
  logic [7:0] inSh = 0, outSh = 0, op = 0;
  logic wel = 1'b0, misoR = 1'b0;
  logic [7:0] opLog[$];
  logic [7:0] adrLog[$];
  int pendA[$];
  logic [7:0] pendD[$];

  always #2 clk = ~clk;

  edidXferEngine #(.DIV_HALF(DIVH), .PAGE_LOG(PLOG)) u_dut (
    .clk(clk), .rstN(rstN), .pwrDnN(pwrDnN), .bigPart(bigPart),
    .loadBit(loadBit), .storeBit(storeBit), .loadClr(loadClr),
    .storeClr(storeClr), .busy(busy), .done(done), .ramAddr(ramAddr),
    .ramWe(ramWe), .ramWdata(ramWdata), .ramRdata(ramRdata),
    .sck(sck), .csN(csN), .mosi(mosi), .miso(miso)
  );

  // behavioural RAM, one-cycle registered read
  always @(posedge clk) begin
    if (ramWe) ram[ramAddr] <= ramWdata;
    ramRdata <= ram[ramAddr];
  end

  assign miso = eePresent ? misoR : 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic eeByte(input logic [7:0] b);
    if (byteN == 0) begin
      op = b;
      opLog.push_back(b);
      if (b == 8'h06) wel = 1'b1;
      outSh = (b == 8'h05) ? {6'b0, wel, wipLeft != 0} : 8'h00;
    end else if (byteN == 1) begin
      adrLog.push_back(b);
      eAddr = {op[3], b};
      if ((op & 8'hF7) == 8'h03) begin
        outSh = eeMem[eAddr];
        eAddr = (eAddr + 1) % 512;
      end
    end else begin
      if ((op & 8'hF7) == 8'h03) begin
        outSh = eeMem[eAddr];
        eAddr = (eAddr + 1) % 512;
      end else if ((op & 8'hF7) == 8'h02) begin
        pendA.push_back(eAddr);
        pendD.push_back(b);
        eAddr = (eAddr & ~15) | ((eAddr + 1) & 15);
      end else if (op == 8'h05) begin
        outSh = {6'b0, wel, wipLeft != 0};
      end
    end
  endtask

  always @(negedge csN) begin
    bitN = 0;
    byteN = 0;
  end

  always @(posedge sck) if (!csN) begin
    inSh = {inSh[6:0], mosi};
    bitN++;
    if (bitN == 8) begin
      bitN = 0;
      eeByte(inSh);
      byteN++;
    end
  end

  always @(negedge sck) if (!csN) misoR = outSh[7 - bitN];

  always @(posedge csN) begin
    if (byteN >= 2 && (op & 8'hF7) == 8'h02 && wel) begin
      foreach (pendA[i]) eeMem[pendA[i]] = pendD[i];
      wipLeft = 3;
      wel = 1'b0;
    end else if (byteN >= 2 && op == 8'h05 && wipLeft > 0) begin
      wipLeft--;
    end
    pendA.delete();
    pendD.delete();
    byteN = 0;
  end

  // per-clock comparison against the protocol rules
  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      if (ramWe) weCnt++;
      if (done) doneCnt++;
      check(!(csN && sck), "R9 sck low with csN high", sck, 0);
      check(busy || csN, "R1 csN high when idle", csN, 1);
      if (sck && prevSck) check(mosi == prevMosi, "R10 mosi stable while sck high", mosi, prevMosi);
      if (sck) hiCnt++;
      else if (hiCnt != 0) begin
        check(hiCnt == DIVH, "R9 sck high width", hiCnt, DIVH);
        hiCnt = 0;
      end
    end
    prevSck = sck;
    prevMosi = mosi;
  end

  task automatic clearLogs();
    opLog.delete();
    adrLog.delete();
    weCnt = 0;
    doneCnt = 0;
  endtask

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    check(done == 1'b1 && busy == 1'b0, {tag, " completion"}, n, 0);
    repeat (3) @(negedge clk);
    check(doneCnt == 1, "R12 single done pulse", doneCnt, 1);
  endtask

  task automatic fillRam(input int seed);
    for (int i = 0; i < 512; i++) ram[i] = 8'((i * seed + 3) ^ (i >> 4));
  endtask

  task automatic cmdBits(input bit ld, input bit st, input string tag);
    @(negedge clk);
    loadBit = ld;
    storeBit = st;
    @(negedge clk);
    if (ld) check(loadClr == 1'b1, {tag, " load clear pulse"}, loadClr, 1);
    if (st) check(storeClr == 1'b1, {tag, " store clear pulse"}, storeClr, 1);
    check(busy == 1'b1, {tag, " busy after command"}, busy, 1);
    loadBit = 1'b0;
    storeBit = 1'b0;
  endtask

  task automatic doStore(input bit big, input string tag);
    int pages = big ? 32 : 16;
    int bytes = big ? 512 : 256;
    int bad = 0, k = 0;
    logic [7:0] expOp;
    bigPart = big;
    for (int i = 0; i < 512; i++) eeMem[i] = 8'hEE;
    fillRam(big ? 13 : 29);
    clearLogs();
    cmdBits(1'b0, 1'b1, tag);
    waitDone(tag);
    for (int i = 0; i < 512; i++)
      if (eeMem[i] !== ((i < bytes) ? ram[i] : 8'hEE)) bad++;
    check(bad == 0, "R7 EEPROM copy matches RAM", bad, 0);
    check(opLog.size() == pages * 6, "R6 transaction count", opLog.size(), pages * 6);
    bad = 0;
    for (int p = 0; p < pages && k + 6 <= opLog.size(); p++) begin
      expOp = (p * 16 >= 256) ? 8'h0A : 8'h02;
      if (opLog[k] != 8'h06) bad++;
      if (opLog[k + 1] != expOp) bad++;
      for (int s = 2; s < 6; s++) if (opLog[k + s] != 8'h05) bad++;
      k += 6;
    end
    check(bad == 0, big ? "R6 page opcode order" : "R3 page opcodes in small part", bad, 0);
  endtask

  initial begin
    int bad;
    for (int i = 0; i < 512; i++) begin
      eeMem[i] = 8'((i * 37 + 11) ^ (i >> 8));
      ram[i] = 8'hA5;
    end

    // R1: reset with power-down input high, no boot load
    pwrDnN = 1'b1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (60) @(negedge clk);
    check(busy == 1'b0 && csN == 1'b1 && sck == 1'b0, "R1 idle after reset", busy, 0);
    check(weCnt == 0, "R1 no RAM writes", weCnt, 0);

    // R2: boot load in power-down mode, 512-byte part
    clearLogs();
    rstN = 1'b0;
    pwrDnN = 1'b0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(busy == 1'b1, "R2 boot load starts", busy, 1);
    waitDone("R2");
    bad = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== eeMem[i]) bad++;
    check(bad == 0, "R2 RAM equals EEPROM", bad, 0);
    check(opLog.size() == 1 && opLog[0] == 8'h03, "R2 read opcode", opLog.size() > 0 ? opLog[0] : -1, 3);
    check(adrLog.size() == 1 && adrLog[0] == 8'h00, "R2 start address", adrLog.size() > 0 ? adrLog[0] : -1, 0);
    check(weCnt == 512, "R2 RAM write count", weCnt, 512);
    pwrDnN = 1'b1;

    // R3 + R4: command load on 256-byte part
    bigPart = 1'b0;
    for (int i = 0; i < 512; i++) ram[i] = 8'h5A;
    clearLogs();
    cmdBits(1'b1, 1'b0, "R4");
    waitDone("R3");
    bad = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== ((i < 256) ? eeMem[i] : 8'h5A)) bad++;
    check(bad == 0, "R3 lower half loaded, upper untouched", bad, 0);
    check(weCnt == 256, "R3 RAM write count", weCnt, 256);

    // R5: store request during a load is dropped
    bigPart = 1'b1;
    clearLogs();
    cmdBits(1'b1, 1'b0, "R5 load");
    repeat (100) @(negedge clk);
    storeBit = 1'b1;
    @(negedge clk);
    check(storeClr == 1'b1, "R5 clear pulse while busy", storeClr, 1);
    storeBit = 1'b0;
    waitDone("R5");
    repeat (200) @(negedge clk);
    check(busy == 1'b0 && opLog.size() == 1, "R5 dropped store", opLog.size(), 1);

    // R6 + R7: store into 512-byte part, then R3 on 256-byte part
    doStore(1'b1, "R6");
    doStore(1'b0, "R3");

    // R8: absent EEPROM loads zeros
    bigPart = 1'b1;
    eePresent = 1'b0;
    for (int i = 0; i < 512; i++) ram[i] = 8'h77;
    clearLogs();
    cmdBits(1'b1, 1'b0, "R8");
    waitDone("R8");
    bad = 0;
    for (int i = 0; i < 512; i++) if (ram[i] !== 8'h00) bad++;
    check(bad == 0, "R8 zeros loaded", bad, 0);
    eePresent = 1'b1;

    // R11: both bits together, load wins
    clearLogs();
    cmdBits(1'b1, 1'b1, "R11");
    waitDone("R11");
    repeat (100) @(negedge clk);
    check(opLog.size() == 1 && opLog[0] == 8'h03, "R11 only load ran", opLog.size(), 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #760000;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=finish", cycles);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule